// File: doc/BRIEF.md
# Half-Bridge Gate Pair With Split Dead Time and Latched Fault

This block turns a single raw PWM level into two gate-drive signals for the high-side and low-side switches of a half-bridge. Whenever the requested level changes, the switch that is on turns off at once. The other switch turns on only after a programmable number of clock cycles. The delay before the high side turns on and the delay before the low side turns on are programmed separately. Switches often turn on and off at different speeds, so each transition can need its own margin.

A hardware fault input overrides everything and holds both switches off. The fault is captured in a latch and stays active until an explicit clear strobe arrives while the fault input is low. After the release, the stage does not jump straight back into conduction. It first waits out a full dead-time interval toward the currently requested level. All inputs are synchronous to the block clock.

Top module: `hbdt_gate_pair`

## Requirements
- R1: After reset, `hs_out`, `ls_out` and `fault_flag` are all 0. The first clock edge after reset starts a dead-time interval toward the level on `pwm_in`.
- R2: `hs_out` and `ls_out` are never 1 in the same cycle.
- R3: A clock edge that samples `pwm_in`=1 while the low side is on turns `ls_out` off after that edge. `hs_out` then goes to 1 after the `dt_rise`-th following edge, so the gap lasts `dt_rise` cycles.
- R4: A clock edge that samples `pwm_in`=0 while the high side is on turns `hs_out` off after that edge. `ls_out` then goes to 1 after `dt_fall` more edges.
- R5: Suppose `pwm_in` reverses during a dead-time interval. The pending turn-on is dropped, and a fresh interval toward the new level starts, using the count for that direction. Neither output pulses.
- R6: The first edge that samples `fault_in`=1 sets `fault_flag` and forces `hs_out` and `ls_out` to 0 after that same edge. They stay 0 while `fault_flag` is 1.
- R7: `fault_flag` clears only on an edge where `fault_clr`=1 and `fault_in`=0. A clear strobe issued while `fault_in`=1 has no effect.
- R8: On the edge that releases the fault, a full dead-time interval toward the current `pwm_in` level begins. The count is `dt_rise` for level 1 and `dt_fall` for level 0.
- R9: A dead-time count of 0 gives plain complementary switching. On the same edge, one output turns off and the other turns on.
- R10: The dead-time count is captured when an interval starts. Changing `dt_rise` or `dt_fall` during an interval does not alter that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Raw requested switch level (1 = high side) |
| dt_rise | input | DT_W | Cycles both switches stay off before the high side turns on |
| dt_fall | input | DT_W | Cycles both switches stay off before the low side turns on |
| fault_in | input | 1 | Hardware fault request, active high |
| fault_clr | input | 1 | Fault release strobe |
| hs_out | output | 1 | High-side gate drive |
| ls_out | output | 1 | Low-side gate drive |
| fault_flag | output | 1 | Latched fault status |

## Verification
The properties assume that every input is synchronous to `clk` and changes only between edges. They also assume that `fault_clr` may be held for several cycles, because a clear repeated while already released is harmless. The stimulus follows these assumptions by driving every input on the falling clock edge. It covers the following:
- directed sequences with unequal rise and fall counts;
- zero counts;
- reversals shorter than the interval;
- counts rewritten mid-interval;
- a clear attempted while the fault is still high.

A seeded random stretch then mixes PWM changes, count changes, fault pulses and clears. A behavioural model that knows nothing of the phase encoding predicts all three outputs on every cycle.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_LOW    = 3'd1,
        PH_HIGH   = 3'd2,
        PH_ARM_HI = 3'd3,
        PH_ARM_LO = 3'd4
    } phase_e;

endpackage

// File: rtl/hbdt_fault_latch.sv
module hbdt_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic fault_clr,
    output logic flt_next,
    output logic flt_q
);
    typedef struct packed {
        logic flt;
    } latch_t;

    latch_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (l_q.flt) begin
            // release only when the source has gone away
            if (fault_clr && !fault_in) l_d.flt = 1'b0;
        end else if (fault_in) begin
            l_d.flt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign flt_next = l_d.flt;
    assign flt_q    = l_q.flt;
endmodule

// File: rtl/hbdt_sequencer.sv
module hbdt_sequencer
    import hbdt_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic [DT_W-1:0] dt_rise,
    input  logic [DT_W-1:0] dt_fall,
    input  logic            force_off,
    output logic            hs_on,
    output logic            ls_on
);
    localparam logic [DT_W-1:0] CNT_ONE  = DT_W'(1);
    localparam logic [DT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        phase_e          ph;
        logic [DT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    // begin a dead-time interval toward lvl, or switch at once for a zero count
    function automatic seq_t launch(input logic lvl,
                                    input logic [DT_W-1:0] r,
                                    input logic [DT_W-1:0] f);
        seq_t            o;
        logic [DT_W-1:0] n;
        n = lvl ? r : f;
        if (n == CNT_ZERO) begin
            o.ph  = lvl ? PH_HIGH : PH_LOW;
            o.cnt = CNT_ZERO;
        end else begin
            o.ph  = lvl ? PH_ARM_HI : PH_ARM_LO;
            o.cnt = n - CNT_ONE;
        end
        return o;
    endfunction

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_OFF:    s_d = launch(pwm_in, dt_rise, dt_fall);
            PH_LOW:    if (pwm_in)  s_d = launch(1'b1, dt_rise, dt_fall);
            PH_HIGH:   if (!pwm_in) s_d = launch(1'b0, dt_rise, dt_fall);
            PH_ARM_HI: begin
                if (!pwm_in)                 s_d = launch(1'b0, dt_rise, dt_fall);
                else if (s_q.cnt == CNT_ZERO) s_d.ph = PH_HIGH;
                else                         s_d.cnt = s_q.cnt - CNT_ONE;
            end
            PH_ARM_LO: begin
                if (pwm_in)                  s_d = launch(1'b1, dt_rise, dt_fall);
                else if (s_q.cnt == CNT_ZERO) s_d.ph = PH_LOW;
                else                         s_d.cnt = s_q.cnt - CNT_ONE;
            end
            default:   s_d.ph = PH_OFF;
        endcase
        if (force_off) begin
            s_d.ph  = PH_OFF;
            s_d.cnt = CNT_ZERO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_OFF;
            s_q.cnt <= CNT_ZERO;
        end else begin
            s_q <= s_d;
        end
    end

    assign hs_on = (s_q.ph == PH_HIGH);
    assign ls_on = (s_q.ph == PH_LOW);
endmodule

// File: rtl/hbdt_gate_pair.sv
module hbdt_gate_pair #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic [DT_W-1:0] dt_rise,
    input  logic [DT_W-1:0] dt_fall,
    input  logic            fault_in,
    input  logic            fault_clr,
    output logic            hs_out,
    output logic            ls_out,
    output logic            fault_flag
);
    logic flt_next;
    logic flt_q;

    hbdt_fault_latch flt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_in  (fault_in),
        .fault_clr (fault_clr),
        .flt_next  (flt_next),
        .flt_q     (flt_q)
    );

    hbdt_sequencer #(.DT_W(DT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_in    (pwm_in),
        .dt_rise   (dt_rise),
        .dt_fall   (dt_fall),
        .force_off (flt_next),
        .hs_on     (hs_out),
        .ls_on     (ls_out)
    );

    assign fault_flag = flt_q;
endmodule

// File: rtl/hbdt_gate_pair_chk.sv
module hbdt_gate_pair_chk #(
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwm_in,
    input logic [DT_W-1:0] dt_rise,
    input logic [DT_W-1:0] dt_fall,
    input logic            fault_in,
    input logic            fault_clr,
    input logic            hs_out,
    input logic            ls_out,
    input logic            fault_flag
);
    // R2: never both switches on
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_out && ls_out));

    // R3: rising request drops the low side after the sampling edge
    p_ls_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_out && pwm_in) |=> !ls_out);

    // R4: falling request drops the high side after the sampling edge
    p_hs_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_out && !pwm_in) |=> !hs_out);

    // R5: high side turns on only while the request is high
    p_hs_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_out) |-> $past(pwm_in));

    // R6: fault forces both off and raises the flag
    p_fault_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> (fault_flag && !hs_out && !ls_out));

    // R6: while latched both stay off
    p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> (!hs_out && !ls_out));

    // R7: clear ignored while the source is still high
    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && (fault_in || !fault_clr)) |=> fault_flag);

    // R7: a valid clear releases the latch
    p_fault_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && fault_clr && !fault_in) |=> !fault_flag);

    // R9: zero rise count switches on the same edge
    p_zero_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_out && pwm_in && !fault_in && dt_rise == '0) |=> hs_out);
endmodule

bind hbdt_gate_pair hbdt_gate_pair_chk #(.DT_W(DT_W)) chk_i (.*);

// File: tb/hbdt_gate_pair_tb_top.sv
module hbdt_gate_pair_tb_top;
    localparam int DT_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwm_in = 1'b0;
    logic [DT_W-1:0] dt_rise = '0;
    logic [DT_W-1:0] dt_fall = '0;
    logic            fault_in = 1'b0;
    logic            fault_clr = 1'b0;
    logic            hs_out, ls_out, fault_flag;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_want   = -1;  // level being approached, -1 = none yet
    int m_gap    = 0;   // edges left before the wanted side conducts
    int m_hs     = 0;
    int m_ls     = 0;
    int m_fault  = 0;

    always #4 clk = ~clk;

    hbdt_gate_pair #(.DT_W(DT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
        .dt_rise(dt_rise), .dt_fall(dt_fall),
        .fault_in(fault_in), .fault_clr(fault_clr),
        .hs_out(hs_out), .ls_out(ls_out), .fault_flag(fault_flag)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // reference model, advanced on each edge from the stable inputs
    always @(posedge clk) begin
        if (rst_n) begin
            int p;
            int fi;
            p  = int'(pwm_in);
            fi = int'(fault_in);
            if (m_fault != 0) begin
                if (fault_clr && fi == 0) begin
                    m_fault = 0;
                    m_want  = -1;
                end
            end else if (fi != 0) begin
                m_fault = 1;
            end
            if (m_fault != 0) begin
                m_hs = 0; m_ls = 0; m_want = -1;
            end else if (p != m_want) begin
                m_want = p;
                m_gap  = (p != 0) ? int'(dt_rise) : int'(dt_fall);
                m_hs = 0; m_ls = 0;
                if (m_gap == 0) begin
                    m_hs = p; m_ls = 1 - p;
                end
            end else if (m_gap > 0) begin
                m_gap--;
                if (m_gap == 0) begin
                    m_hs = p; m_ls = 1 - p;
                end
            end
        end
    end

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check(cur_req, int'(hs_out), m_hs, "hs_out");
            check(cur_req, int'(ls_out), m_ls, "ls_out");
            check(cur_req, int'(fault_flag), m_fault, "fault_flag");
            if (hs_out && ls_out) check("R2", 1, 0, "both on");
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        check("R1", int'(hs_out), 0, "reset hs_out");
        check("R1", int'(ls_out), 0, "reset ls_out");
        check("R1", int'(fault_flag), 0, "reset fault_flag");
        dt_rise = 8'd3;
        dt_fall = 8'd5;
        rst_n = 1'b1;
        cur_req = "R1";
        idle(8);
        check("R1", int'(ls_out), 1, "low side after start");

        // R3 / R4 unequal counts
        cur_req = "R3";
        pwm_in = 1'b1; idle(1);
        @(posedge clk); #2;
        check("R3", int'(ls_out), 0, "ls drops after rise edge");
        @(negedge clk); idle(5);
        check("R3", int'(hs_out), 1, "hs on after dt_rise");
        cur_req = "R4";
        pwm_in = 1'b0; idle(8);
        check("R4", int'(ls_out), 1, "ls on after dt_fall");

        // R5 short reversals
        cur_req = "R5";
        pwm_in = 1'b1; idle(2);
        pwm_in = 1'b0; idle(2);
        pwm_in = 1'b1; idle(1);
        pwm_in = 1'b0; idle(10);
        check("R5", int'(ls_out), 1, "settled low after reversals");

        // R10 count rewritten mid-interval
        cur_req = "R10";
        dt_rise = 8'd6;
        pwm_in = 1'b1; idle(2);
        dt_rise = 8'd1; idle(2);
        check("R10", int'(hs_out), 0, "interval kept old count");
        idle(6);
        check("R10", int'(hs_out), 1, "hs on after old count");

        // R9 zero counts
        cur_req = "R9";
        dt_rise = 8'd0; dt_fall = 8'd0;
        pwm_in = 1'b0; idle(1);
        check("R9", int'(ls_out), 1, "zero fall immediate");
        pwm_in = 1'b1; idle(1);
        check("R9", int'(hs_out), 1, "zero rise immediate");
        pwm_in = 1'b0; idle(1);
        pwm_in = 1'b1; idle(3);

        // R6 / R7 / R8 fault handling
        dt_rise = 8'd4; dt_fall = 8'd2;
        cur_req = "R6";
        fault_in = 1'b1; idle(1);
        check("R6", int'(hs_out), 0, "fault forces off");
        check("R6", int'(fault_flag), 1, "fault latched");
        cur_req = "R7";
        fault_clr = 1'b1; idle(2);
        check("R7", int'(fault_flag), 1, "clear ignored while fault high");
        fault_clr = 1'b0;
        fault_in = 1'b0; idle(3);
        check("R7", int'(fault_flag), 1, "latch holds after source drops");
        cur_req = "R8";
        fault_clr = 1'b1; idle(1);
        fault_clr = 1'b0;
        check("R8", int'(fault_flag), 0, "released");
        check("R8", int'(hs_out), 0, "full interval after release");
        idle(4);
        check("R8", int'(hs_out), 1, "hs after dt_rise following release");

        // random mix
        cur_req = "R2";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 12) pwm_in = ~pwm_in;
            if (r == 50) dt_rise = DT_W'($urandom_range(0, 7));
            if (r == 51) dt_fall = DT_W'($urandom_range(0, 7));
            fault_in  = (r == 60 || r == 61);
            fault_clr = (r >= 70 && r < 75);
            idle(1);
        end
        fault_in = 1'b0; fault_clr = 1'b0;
        idle(20);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule